// File: doc/BRIEF.md
# Spare Store Substitution Controller

This block sits between a client that reads and writes a small set of logical stores and a row of physical storage units, some of which are held back as standby. At reset the first `N_ACTIVE` units back logical slots 0 upward in order; the rest form a shared pool of spares. Every write goes to the unit the slot currently maps to. The block then reads the same location back and compares it with the value written.

A difference between the written and the read-back value counts as a unit failure. The controller marks that unit faulty and raises a maintenance alarm. It moves the slot onto the lowest-numbered usable spare and writes the data again there, checking it the same way, before it acknowledges the request. When no spare is left, the request ends with an error response and a sticky system-failure flag. Maintenance reports a repaired unit through a repair strobe. That clears the unit's fault bit and, if no slot uses the unit, returns it to the spare pool.

Top module: `spare_sub_ctrl`

## Requirements
- R1: After reset, slot i maps to physical unit i, `unit_fault` is all zero, and `alarm`, `sys_fail` and `done` are low.
- R2: A write drives `phy_we` for one cycle to the mapped unit. On the next cycle `phy_re` is driven to the same unit and address. When the read-back value equals the written value, the request ends with `done` high for exactly one cycle and `resp_err` low.
- R3: On a read-back mismatch, the failing unit's bit in `unit_fault` is set, `alarm` rises, and the slot is remapped to a spare. The write is reissued to that spare and verified again before `done`.
- R4: A spare is taken in ascending physical index order, skipping units that are in use or faulty. A faulty unit is never chosen until it has been repaired.
- R5: On a mismatch with no usable spare, `sys_fail` is set and the request ends with a single `done` pulse and `resp_err` high. The slot keeps its mapping.
- R6: A `rep_valid` cycle carrying index `rep_unit` clears that unit's fault bit and clears `sys_fail`. A repaired unit that no slot maps to becomes an eligible spare.
- R7: A read uses the current slot map. Its data appears on `rdata` in the same cycle as the single `done` pulse, with `resp_err` low.
- R8: `alarm` is high exactly when at least one bit of `unit_fault` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_slot | input | SLOT_W | Logical slot index |
| req_addr | input | ADDR_W | Location inside the unit |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Valid with `done`: write could not be stored |
| rdata | output | DATA_W | Read data, valid with `done` |
| phy_sel | output | UNIT_W | Selected physical unit |
| phy_we | output | 1 | Physical write strobe |
| phy_re | output | 1 | Physical read strobe |
| phy_addr | output | ADDR_W | Physical location |
| phy_wdata | output | DATA_W | Physical write data |
| phy_rdata | input | DATA_W | Read data from the selected unit, one cycle after `phy_re` |
| rep_valid | input | 1 | Repair-done strobe |
| rep_unit | input | UNIT_W | Index of the repaired unit |
| unit_fault | output | N_UNITS | Per-unit fault bits |
| alarm | output | 1 | Maintenance alarm |
| sys_fail | output | 1 | No spare was available for a failed write |

## Verification
The bench builds the block with five units, three of them active, 8-bit data and 8 locations per unit. With only two spares, a few injected faults are enough to use up the pool. The bench injects a fault into a spare and checks that the next swap skips it. It then uses up the pool to reach the error response. Finally it repairs units to show that a repaired unit is reused ahead of one that is still faulty. Faults are injected as per-unit bit-flip masks in the bench's behavioural stores.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RB,
    ST_CMP,
    ST_RDW,
    ST_RDC
  } ssc_state_e;
endpackage

// File: rtl/ssc_unit_pool.sv
module ssc_unit_pool #(
  parameter int N_UNITS  = 6,
  parameter int N_ACTIVE = 4,
  localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fail_en,
  input  logic [UNIT_W-1:0] fail_unit,
  input  logic              take_en,
  input  logic [UNIT_W-1:0] take_unit,
  input  logic              rep_en,
  input  logic [UNIT_W-1:0] rep_unit,
  output logic [N_UNITS-1:0] fault_q,
  output logic              alarm_q,
  output logic              spare_ok,
  output logic [UNIT_W-1:0] spare_idx
);
  logic [N_UNITS-1:0] in_use_q, in_use_n, fault_n;
  logic [N_UNITS-1:0] usable;

  // usable spare: not mapped and not faulty
  genvar g;
  generate
    for (g = 0; g < N_UNITS; g++) begin : g_usable
      assign usable[g] = !in_use_q[g] && !fault_q[g];
    end
  endgenerate

  // lowest index wins
  always_comb begin
    spare_ok  = 1'b0;
    spare_idx = '0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (usable[i]) begin
        spare_ok  = 1'b1;
        spare_idx = UNIT_W'(i);
      end
    end
  end

  always_comb begin
    fault_n  = fault_q;
    in_use_n = in_use_q;
    if (fail_en) fault_n[fail_unit] = 1'b1;
    if (take_en) begin
      in_use_n[fail_unit] = 1'b0;
      in_use_n[take_unit] = 1'b1;
    end
    // a repair report is applied last
    if (rep_en && (int'(rep_unit) < N_UNITS)) fault_n[rep_unit] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= '0;
      alarm_q <= 1'b0;
      for (int i = 0; i < N_UNITS; i++) in_use_q[i] <= (i < N_ACTIVE);
    end else begin
      fault_q  <= fault_n;
      in_use_q <= in_use_n;
      alarm_q  <= |fault_n;
    end
  end
endmodule

// File: rtl/ssc_map.sv
module ssc_map #(
  parameter int N_UNITS  = 6,
  parameter int N_ACTIVE = 4,
  localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int SLOT_W  = (N_ACTIVE > 1) ? $clog2(N_ACTIVE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [UNIT_W-1:0] wr_unit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [UNIT_W-1:0] rd_unit
);
  logic [UNIT_W-1:0] tbl_q [N_ACTIVE];

  genvar g;
  generate
    for (g = 0; g < N_ACTIVE; g++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst)
          tbl_q[g] <= UNIT_W'(g);
        else if (wr_en && (int'(wr_slot) == g))
          tbl_q[g] <= wr_unit;
      end
    end
  endgenerate

  assign rd_unit = (int'(rd_slot) < N_ACTIVE) ? tbl_q[rd_slot] : '0;
endmodule

// File: rtl/spare_sub_ctrl.sv
module spare_sub_ctrl
  import ssc_pkg::*;
#(
  parameter int N_UNITS  = 6,
  parameter int N_ACTIVE = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  localparam int UNIT_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
  localparam int SLOT_W  = (N_ACTIVE > 1) ? $clog2(N_ACTIVE) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [SLOT_W-1:0]  req_slot,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               done,
  output logic               resp_err,
  output logic [DATA_W-1:0]  rdata,
  output logic [UNIT_W-1:0]  phy_sel,
  output logic               phy_we,
  output logic               phy_re,
  output logic [ADDR_W-1:0]  phy_addr,
  output logic [DATA_W-1:0]  phy_wdata,
  input  logic [DATA_W-1:0]  phy_rdata,
  input  logic               rep_valid,
  input  logic [UNIT_W-1:0]  rep_unit,
  output logic [N_UNITS-1:0] unit_fault,
  output logic               alarm,
  output logic               sys_fail
);
  ssc_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [UNIT_W-1:0] map_unit;
  logic              spare_ok;
  logic [UNIT_W-1:0] spare_idx;
  logic              mismatch, fail_en, take_en;

  assign mismatch = (phy_rdata != phy_wdata);
  assign fail_en  = (state_q == ST_CMP) && mismatch;
  assign take_en  = fail_en && spare_ok;

  ssc_map #(.N_UNITS(N_UNITS), .N_ACTIVE(N_ACTIVE)) u_map (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (take_en),
    .wr_slot (slot_q),
    .wr_unit (spare_idx),
    .rd_slot (req_slot),
    .rd_unit (map_unit)
  );

  ssc_unit_pool #(.N_UNITS(N_UNITS), .N_ACTIVE(N_ACTIVE)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .fail_en   (fail_en),
    .fail_unit (phy_sel),
    .take_en   (take_en),
    .take_unit (spare_idx),
    .rep_en    (rep_valid),
    .rep_unit  (rep_unit),
    .fault_q   (unit_fault),
    .alarm_q   (alarm),
    .spare_ok  (spare_ok),
    .spare_idx (spare_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      slot_q    <= '0;
      done      <= 1'b0;
      resp_err  <= 1'b0;
      rdata     <= '0;
      phy_sel   <= '0;
      phy_we    <= 1'b0;
      phy_re    <= 1'b0;
      phy_addr  <= '0;
      phy_wdata <= '0;
      sys_fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rep_valid) sys_fail <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            slot_q   <= req_slot;
            phy_sel  <= map_unit;
            phy_addr <= req_addr;
            if (req_write) begin
              phy_wdata <= req_wdata;
              phy_we    <= 1'b1;
              state_q   <= ST_WR;
            end else begin
              phy_re  <= 1'b1;
              state_q <= ST_RDW;
            end
          end
        end
        ST_WR: begin
          phy_we  <= 1'b0;
          phy_re  <= 1'b1;
          state_q <= ST_RB;
        end
        ST_RB: begin
          phy_re  <= 1'b0;
          state_q <= ST_CMP;
        end
        ST_CMP: begin
          if (!mismatch) begin
            done     <= 1'b1;
            resp_err <= 1'b0;
            state_q  <= ST_IDLE;
          end else if (spare_ok) begin
            phy_sel <= spare_idx;
            phy_we  <= 1'b1;
            state_q <= ST_WR;
          end else begin
            sys_fail <= 1'b1;
            done     <= 1'b1;
            resp_err <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        ST_RDW: begin
          phy_re  <= 1'b0;
          state_q <= ST_RDC;
        end
        ST_RDC: begin
          rdata    <= phy_rdata;
          done     <= 1'b1;
          resp_err <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spare_sub_ctrl_chk.sv
module spare_sub_ctrl_chk #(
  parameter int N_UNITS = 6,
  parameter int UNIT_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               done,
  input logic               resp_err,
  input logic               sys_fail,
  input logic               alarm,
  input logic [N_UNITS-1:0] unit_fault,
  input logic               phy_we,
  input logic               phy_re,
  input logic [UNIT_W-1:0]  phy_sel,
  input logic               rep_valid,
  input logic [UNIT_W-1:0]  rep_unit
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_readback_follows: assert property (@(posedge clk) disable iff (rst)
    phy_we |=> (phy_re && $stable(phy_sel)));

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(phy_we && phy_re));

  a_r5_err_means_fail: assert property (@(posedge clk) disable iff (rst)
    (done && resp_err) |-> sys_fail);

  a_r6_repair_clears: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && (int'(rep_unit) < N_UNITS)) |=> !unit_fault[$past(rep_unit)]);

  a_r8_alarm_tracks: assert property (@(posedge clk) disable iff (rst)
    alarm == (|unit_fault));
endmodule

bind spare_sub_ctrl spare_sub_ctrl_chk #(.N_UNITS(N_UNITS), .UNIT_W(UNIT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .done       (done),
  .resp_err   (resp_err),
  .sys_fail   (sys_fail),
  .alarm      (alarm),
  .unit_fault (unit_fault),
  .phy_we     (phy_we),
  .phy_re     (phy_re),
  .phy_sel    (phy_sel),
  .rep_valid  (rep_valid),
  .rep_unit   (rep_unit)
);

// File: tb/spare_sub_ctrl_test.sv
module spare_sub_ctrl_test;
  localparam int NU = 5;
  localparam int NA = 3;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int UW = $clog2(NU);
  localparam int SW = $clog2(NA);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [SW-1:0] req_slot = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done, resp_err;
  logic [DW-1:0] rdata;
  logic [UW-1:0] phy_sel;
  logic          phy_we, phy_re;
  logic [AW-1:0] phy_addr;
  logic [DW-1:0] phy_wdata;
  logic [DW-1:0] phy_rdata;
  logic          rep_valid = 1'b0;
  logic [UW-1:0] rep_unit = '0;
  logic [NU-1:0] unit_fault;
  logic          alarm, sys_fail;

  always #2 clk = ~clk;

  spare_sub_ctrl #(.N_UNITS(NU), .N_ACTIVE(NA), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_slot(req_slot),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .resp_err(resp_err), .rdata(rdata),
    .phy_sel(phy_sel), .phy_we(phy_we), .phy_re(phy_re),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
    .rep_valid(rep_valid), .rep_unit(rep_unit),
    .unit_fault(unit_fault), .alarm(alarm), .sys_fail(sys_fail)
  );

  // behavioural stores with per-unit bit-flip masks
  logic [DW-1:0] mem [NU][1<<AW];
  logic [DW-1:0] cor [NU];
  logic [UW-1:0] last_we_sel;
  initial begin
    for (int u = 0; u < NU; u++) begin
      cor[u] = '0;
      for (int a = 0; a < (1<<AW); a++) mem[u][a] = '0;
    end
  end
  always @(posedge clk) begin
    if (phy_we) begin
      mem[phy_sel][phy_addr] <= phy_wdata ^ cor[phy_sel];
      last_we_sel <= phy_sel;
    end
    if (phy_re) phy_rdata <= mem[phy_sel][phy_addr];
  end

  int n_tests = 0;
  int n_fail  = 0;
  int n_cyc   = 0;
  logic got_err;
  logic [DW-1:0] got_data;

  always @(posedge clk) begin
    n_cyc <= n_cyc + 1;
    if (n_cyc > 20000) begin
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", n_cyc);
      n_fail = n_fail + 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input int slot, input int addr, input logic [DW-1:0] d);
    int pulses = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_slot = SW'(slot);
    req_addr = AW'(addr); req_wdata = d;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin
        pulses++;
        got_err = resp_err; got_data = rdata;
        req_valid = 1'b0;
        @(negedge clk);
        if (done) pulses++;
        break;
      end
    end
    req_valid = 1'b0;
    chk("R2 single done pulse", pulses, 1);
  endtask

  task automatic repair(input int u);
    @(negedge clk);
    rep_valid = 1'b1; rep_unit = UW'(u);
    @(negedge clk);
    rep_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 faults clear", unit_fault, 0);
    chk("R1 alarm low", alarm, 0);
    chk("R1 sys_fail low", sys_fail, 0);
    chk("R1 done low", done, 0);
    for (int s = 0; s < NA; s++) begin
      do_req(1'b1, s, s, DW'(8'h10 + s));
      chk("R1 identity map", last_we_sel, s);
      chk("R2 stored", mem[s][s], 8'h10 + s);
      chk("R2 no error", got_err, 0);
    end
  endtask

  task automatic t_write_read;
    do_req(1'b1, 0, 2, 8'hA5);
    chk("R2 write ok", got_err, 0);
    do_req(1'b0, 0, 2, '0);
    chk("R7 read data", got_data, 8'hA5);
    chk("R7 read no error", got_err, 0);
    do_req(1'b1, 2, 7, 8'h5A);
    do_req(1'b0, 2, 7, '0);
    chk("R7 read slot2", got_data, 8'h5A);
  endtask

  task automatic t_swap;
    cor[1] = 8'h01;
    do_req(1'b1, 1, 3, 8'h3C);
    chk("R3 swap write ok", got_err, 0);
    chk("R3 fault bit", unit_fault, 5'b00010);
    chk("R3 alarm", alarm, 1);
    chk("R4 lowest spare", last_we_sel, 3);
    chk("R3 spare holds data", mem[3][3], 8'h3C);
    do_req(1'b0, 1, 3, '0);
    chk("R7 read after remap", got_data, 8'h3C);
  endtask

  task automatic t_skip_faulty;
    cor[3] = 8'h80;
    do_req(1'b1, 1, 4, 8'h77);
    chk("R4 next spare", last_we_sel, 4);
    chk("R4 faults", unit_fault, 5'b01010);
    chk("R3 write ok", got_err, 0);
  endtask

  task automatic t_no_spare;
    cor[4] = 8'h01;
    do_req(1'b1, 1, 5, 8'h11);
    chk("R5 error resp", got_err, 1);
    chk("R5 sys_fail", sys_fail, 1);
    chk("R5 faults", unit_fault, 5'b11010);
    chk("R5 mapping kept", last_we_sel, 4);
    do_req(1'b0, 0, 2, '0);
    chk("R7 other slot intact", got_data, 8'hA5);
  endtask

  task automatic t_repair;
    cor[1] = '0;
    repair(1);
    chk("R6 fault cleared", unit_fault, 5'b11000);
    chk("R6 sys_fail cleared", sys_fail, 0);
    chk("R8 alarm still set", alarm, 1);
    do_req(1'b1, 1, 6, 8'h42);
    chk("R6 repaired unit reused", last_we_sel, 1);
    chk("R4 faulty unit 3 skipped", got_err, 0);
    do_req(1'b0, 1, 6, '0);
    chk("R7 read new map", got_data, 8'h42);
    cor[3] = '0; cor[4] = '0;
    repair(3);
    repair(4);
    chk("R6 all clear", unit_fault, 0);
    chk("R8 alarm low", alarm, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_swap();
    t_skip_faulty();
    t_no_spare();
    t_repair();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule